// File: doc/BRIEF.md
# Additive Recurrence Sequence Generator

This block emits one term of a fixed integer sequence on each cycle in which its advance input is high. A new term is the sum of the term three places back and the term two places back. The seed is 0, 1, 1. The full period is 0, 1, 1, 1, 2, 2, 3, 4, 5, 7, 9, 12, 16, 21, 28, 37. After 37 the generator reloads the seed, so the pattern repeats without end.

The state is a sliding window of three registers. The output term is read from the oldest of the three. A small counter tracks the position of the current term within the period, and the reload happens when that counter wraps. With the index and the start-of-period flag, a consumer can align to period boundaries without decoding the term values.

Top module: `addseq_gen`

## Requirements
- R1: A synchronous active-high reset sets the outputs to term 0, index 0 and start flag 1 at the clock edge where reset is sampled high. Reset takes priority over advance.
- R2: On successive advances from reset, the term output walks through 0, 1, 1, 1, 2, 2, 3, 4, 5, 7, 9, 12, 16, 21, 28, 37. Each advance changes the output at the clock edge where advance is sampled high.
- R3: For any index of 3 or more, the term equals the term three advances earlier plus the term two advances earlier.
- R4: While advance is low, the term, the index and the start flag keep their values.
- R5: Each advance raises the index by one, from 0 up to 15.
- R6: The advance taken at index 15 (term 37) returns the index to 0 and the term to 0, so the period is 16 advances.
- R7: The start flag is 1 exactly when the index is 0.
- R8: The term output never exceeds 37 and fits in 6 bits.
- R9: A reset applied in the middle of the period restarts the sequence at term 0, index 0, even if advance is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance to the next term when high |
| term_o | output | 6 | Current term of the sequence |
| idx_o | output | 4 | Position of the current term in the period, 0 to 15 |
| first_o | output | 1 | High on the first term of each period |

## Verification
The assertions assume that reset is asserted at the first clock edge. They also assume advance and reset are clean synchronous levels, so every recurrence or hold check sees only post-reset history. The recurrence check looks back only when the index is at least 3. The index can reach 3 only after three advances since the last reset, so the check never spans a reset or a period wrap. The bench changes inputs only on the falling edge. It starts every scenario from an explicit reset, and it interleaves idle cycles and mid-period resets so that the held and restarted states are reached from many positions in the period.

// File: rtl/addseq_pkg.sv
package addseq_pkg;
  parameter int TERM_W = 6;
  parameter int ACC_W  = TERM_W + 1;
  parameter int PERIOD = 16;
  parameter int IDX_W  = $clog2(PERIOD);

  localparam logic [TERM_W-1:0] SEED_OLD = TERM_W'(0);
  localparam logic [ACC_W-1:0]  SEED_MID = ACC_W'(1);
  localparam logic [ACC_W-1:0]  SEED_NEW = ACC_W'(1);
endpackage

// File: rtl/addseq_phase.sv
module addseq_phase
  import addseq_pkg::*;
#(
  parameter int P_PERIOD = PERIOD,
  parameter int P_IDX_W  = IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  output logic [P_IDX_W-1:0] idx,
  output logic               wrap,
  output logic               first
);
  localparam logic [P_IDX_W-1:0] LAST = P_IDX_W'(P_PERIOD - 1);

  assign wrap = adv && (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      first <= 1'b1;
    end else if (adv) begin
      if (idx == LAST) begin
        idx   <= '0;
        first <= 1'b1;
      end else begin
        idx   <= idx + 1'b1;
        first <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/addseq_window.sv
module addseq_window
  import addseq_pkg::*;
#(
  parameter int P_TERM_W = TERM_W,
  parameter int P_ACC_W  = ACC_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic                reload,
  output logic [P_TERM_W-1:0] oldest
);
  logic [P_ACC_W-1:0] middle;
  logic [P_ACC_W-1:0] newest;
  logic [P_ACC_W-1:0] feedback;

  assign feedback = P_ACC_W'(oldest) + middle;

  always_ff @(posedge clk) begin
    if (rst || (adv && reload)) begin
      oldest <= P_TERM_W'(SEED_OLD);
      middle <= P_ACC_W'(SEED_MID);
      newest <= P_ACC_W'(SEED_NEW);
    end else if (adv) begin
      oldest <= middle[P_TERM_W-1:0];
      middle <= newest;
      newest <= feedback;
    end
  end
endmodule

// File: rtl/addseq_gen.sv
module addseq_gen
  import addseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_en,
  output logic [TERM_W-1:0] term_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              first_o
);
  logic wrap;

  addseq_phase #(.P_PERIOD(PERIOD), .P_IDX_W(IDX_W)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .adv   (adv_en),
    .idx   (idx_o),
    .wrap  (wrap),
    .first (first_o)
  );

  addseq_window #(.P_TERM_W(TERM_W), .P_ACC_W(ACC_W)) u_window (
    .clk    (clk),
    .rst    (rst),
    .adv    (adv_en),
    .reload (wrap),
    .oldest (term_o)
  );
endmodule

// File: rtl/addseq_gen_chk.sv
module addseq_gen_chk
  import addseq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              adv_en,
  input logic [TERM_W-1:0] term_o,
  input logic [IDX_W-1:0]  idx_o,
  input logic              first_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PERIOD - 1);

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (term_o == '0 && idx_o == '0 && first_o)); // R1
  AST_RECURRENCE: assert property (@(posedge clk) disable iff (rst)
    (idx_o >= IDX_W'(3) && $past(adv_en) && $past(adv_en, 2) && $past(adv_en, 3))
      |-> ({1'b0, term_o} == {1'b0, $past(term_o, 3)} + {1'b0, $past(term_o, 2)})); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> ($stable(term_o) && $stable(idx_o) && $stable(first_o))); // R4
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv_en && idx_o != LAST) |=> (idx_o == $past(idx_o) + 1'b1)); // R5
  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv_en && idx_o == LAST) |=> (idx_o == '0 && term_o == '0)); // R6
  AST_FIRST_FLAG: assert property (@(posedge clk) disable iff (rst)
    first_o == (idx_o == '0)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    term_o <= TERM_W'(37)); // R8
endmodule

bind addseq_gen addseq_gen_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .adv_en  (adv_en),
  .term_o  (term_o),
  .idx_o   (idx_o),
  .first_o (first_o)
);

// File: tb/addseq_gen_tb.sv
module addseq_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adv_en = 1'b0;
  logic [5:0] term_o;
  logic [3:0] idx_o;
  logic       first_o;
  int total = 0;
  int bad = 0;

  int exp_tab [16] = '{0, 1, 1, 1, 2, 2, 3, 4, 5, 7, 9, 12, 16, 21, 28, 37};

  always #2 clk = ~clk;

  addseq_gen u_dut (
    .clk(clk), .rst(rst), .adv_en(adv_en),
    .term_o(term_o), .idx_o(idx_o), .first_o(first_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs applied on a falling edge take effect at the next rising edge,
  // results are sampled at the falling edge after it
  task automatic tick(input logic r, input logic e);
    rst = r;
    adv_en = e;
    @(negedge clk);
  endtask

  task automatic check_state(input string req, input int pos);
    check({req, " term"}, term_o, exp_tab[pos]);
    check({req, " idx"}, idx_o, pos);
    check({req, " first"}, first_o, (pos == 0) ? 1 : 0);
  endtask

  task automatic t_reset;
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b1);
    check_state("R1", 0);
    tick(1'b0, 1'b0);
    check_state("R1", 0);
  endtask

  task automatic t_sequence;
    int pos = 0;
    tick(1'b1, 1'b0);
    for (int n = 0; n < 48; n++) begin
      tick(1'b0, 1'b1);
      pos = (pos + 1) % 16;
      check_state("R2 R5 R7", pos);
      check("R8", (term_o <= 37) ? 1 : 0, 1);
      if (pos >= 3)
        check("R3", term_o, exp_tab[pos - 3] + exp_tab[pos - 2]);
      if (pos == 0)
        check("R6", term_o, 0);
    end
  endtask

  task automatic t_hold;
    tick(1'b1, 1'b0);
    for (int k = 0; k < 9; k++) tick(1'b0, 1'b1);
    for (int k = 0; k < 5; k++) begin
      tick(1'b0, 1'b0);
      check_state("R4", 9);
    end
    tick(1'b0, 1'b1);
    check_state("R4", 10);
  endtask

  task automatic t_mid_reset;
    tick(1'b1, 1'b0);
    for (int k = 0; k < 6; k++) tick(1'b0, 1'b1);
    check_state("R9", 6);
    tick(1'b1, 1'b1);
    check_state("R9", 0);
    tick(1'b0, 1'b1);
    check_state("R9", 1);
    for (int k = 0; k < 14; k++) tick(1'b0, 1'b1);
    check_state("R9", 15);
    tick(1'b0, 1'b1);
    check_state("R6", 0);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sequence();
    t_hold();
    t_mid_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule